// File: doc/BRIEF.md
# Once-per-second update sequencer

This block turns a free-running 32.768 kHz oscillator tick into the once-per-second update strobe of a time-of-day counter. It keeps a countdown chain that wraps once per second. A 3-bit divider control field decides whether that chain runs, is frozen, or is held parked half a second before its next update. Ahead of each update it raises an update-in-progress flag, so that software polling the time fields knows a change is coming. The flag stays high through a fixed update window. When the window closes, the block emits an update-ended pulse.

A software-driven hold input suppresses updates while the time fields are being loaded. During the hold the chain keeps counting, so the second boundary does not drift. The calendar arithmetic and the register bus sit in neighbouring blocks. They consume the strobe, the flag and the pulse.

Top module: `update_chain_ctrl`

## Requirements
- R1: After reset all three outputs are low, and the chain is parked at its half-second point, as if the hold pattern had just been applied.
- R2: With `div_ctl` = 3'b010 the chain runs. `update_stb` is a one-cycle pulse repeating every TICKS_PER_SEC cycles.
- R3: With `div_ctl` = 3'b110 or 3'b111 the chain is held at its half-second point and no output is raised. After a return to 3'b010, the first `update_stb` is high in the cycle that follows the TICKS_PER_SEC/2-th rising edge sampling 3'b010, counting the first such edge.
- R4: Any `div_ctl` value other than 3'b010, 3'b110 and 3'b111 freezes the chain and raises no output. Once running resumes, the next update is late by exactly the number of frozen edges.
- R5: `uip` rises exactly GUARD_TICKS cycles before the cycle in which `update_stb` is high. Whenever `uip` is low, no `update_stb` can follow within GUARD_TICKS cycles.
- R6: `uip` stays high through the strobe cycle and the UPDATE_TICKS-1 cycles after it. `update_done` is high for one cycle, UPDATE_TICKS cycles after the strobe, and `uip` is low in that same cycle.
- R7: A rising edge that samples `set_hold` high produces no `update_stb`, no `update_done` and no `uip` in the following cycle. The chain keeps counting, so the first update after release lands on the original one-second grid.
- R8: `update_stb` and `update_done` are never high together, and neither is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator tick, one rising edge per 1/TICKS_PER_SEC second |
| rst_n | input | 1 | Active-low synchronous reset |
| div_ctl | input | 3 | Divider control: 010 run, 11x hold parked, others freeze |
| set_hold | input | 1 | High while software loads the time; suppresses updates |
| update_stb | output | 1 | One-cycle pulse that advances the time fields |
| uip | output | 1 | Update-in-progress flag, high across guard and update window |
| update_done | output | 1 | One-cycle pulse when the update window ends |

## Verification
The bench builds the block with TICKS_PER_SEC = 64, GUARD_TICKS = 4 and UPDATE_TICKS = 6. With these values a simulated second lasts 64 cycles. Several full seconds therefore fit in a short run, including:
- the half-second first update after both hold patterns;
- a freeze that walks through all five stopping patterns;
- a hold input kept across a whole update.

With a guard and window this short, a single-cycle error in the position of the flag's edges or of the ended pulse shows up as a cycle mismatch.

// File: rtl/update_chain_ctrl.sv
module update_chain_ctrl #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int GUARD_TICKS   = 8,
  parameter int UPDATE_TICKS  = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] div_ctl,
  input  logic       set_hold,
  output logic       update_stb,
  output logic       uip,
  output logic       update_done
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam int WW = $clog2(UPDATE_TICKS + 1);
  localparam logic [CW-1:0] LAST_V  = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF_V  = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] GUARD_V = CW'(TICKS_PER_SEC - 1 - GUARD_TICKS);
  localparam logic [WW-1:0] WIN_V   = WW'(UPDATE_TICKS);
  localparam logic [WW-1:0] ONE_W   = WW'(1);

  logic [CW-1:0] cnt;
  logic [WW-1:0] win;

  wire running  = (div_ctl == 3'b010);
  wire parked   = (div_ctl[2:1] == 2'b11);
  wire wrap     = running && (cnt == LAST_V);
  wire in_guard = running && (cnt >= GUARD_V);
  wire live     = running && !set_hold;

  always_ff @(posedge clk) begin
    if (!rst_n || parked)
      cnt <= HALF_V;
    else if (running)
      cnt <= wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !live)
      win <= '0;
    else if (wrap)
      win <= WIN_V;
    else if (win != '0)
      win <= win - ONE_W;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      update_stb  <= 1'b0;
      uip         <= 1'b0;
      update_done <= 1'b0;
    end else begin
      update_stb  <= wrap && !set_hold;
      uip         <= live && (in_guard || win > ONE_W);
      update_done <= live && (win == ONE_W);
    end
  end
endmodule

// File: rtl/update_chain_ctrl_checker.sv
module update_chain_ctrl_checker #(
  parameter int GUARD_TICKS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] div_ctl,
  input logic       set_hold,
  input logic       update_stb,
  input logic       uip,
  input logic       update_done
);
  localparam int HW = $clog2(GUARD_TICKS + 2);
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)
      hi_run <= '0;
    else if (!uip)
      hi_run <= '0;
    else if (hi_run < HW'(GUARD_TICKS))
      hi_run <= hi_run + 1'b1;
  end

  assert_guard_before_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |-> (hi_run >= HW'(GUARD_TICKS)));

  assert_flag_over_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |-> uip);

  assert_flag_low_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |-> !uip);

  assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_hold |=> (!update_stb && !update_done && !uip));

  assert_parked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl[2:1] == 2'b11) |=> (!update_stb && !update_done && !uip));

  assert_frozen_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl != 3'b010 && div_ctl[2:1] != 2'b11) |=> (!update_stb && !update_done && !uip));

  assert_pulses_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({update_stb, update_done}));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |=> !update_stb);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |=> !update_done);
endmodule

bind update_chain_ctrl update_chain_ctrl_checker #(.GUARD_TICKS(GUARD_TICKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .div_ctl(div_ctl), .set_hold(set_hold),
  .update_stb(update_stb), .uip(uip), .update_done(update_done)
);

// File: tb/update_chain_ctrl_tb_top.sv
module update_chain_ctrl_tb_top;
  localparam int TPS  = 64;
  localparam int GRD  = 4;
  localparam int UPD  = 6;
  localparam int HALF = TPS / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] div_ctl = 3'b110;
  logic set_hold = 1'b0;
  logic update_stb, uip, update_done;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic prev_uip = 1'b0;

  byte   exp_kind[$];
  int    exp_cyc[$];
  string exp_req[$];
  string cur_req = "R1";

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  update_chain_ctrl #(.TICKS_PER_SEC(TPS), .GUARD_TICKS(GRD), .UPDATE_TICKS(UPD)) dut_i (
    .clk(clk), .rst_n(rst_n), .div_ctl(div_ctl), .set_hold(set_hold),
    .update_stb(update_stb), .uip(uip), .update_done(update_done)
  );

  task automatic push_ev(byte k, int c, string r);
    exp_kind.push_back(k);
    exp_cyc.push_back(c);
    exp_req.push_back(r);
  endtask

  task automatic push_update(int s, string r);
    push_ev("U", s - GRD, "R5");
    push_ev("S", s, r);
    push_ev("D", s + UPD, "R6");
    push_ev("F", s + UPD, "R6");
  endtask

  task automatic take(byte k);
    checks++;
    if (exp_kind.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event %c at cycle %0d (expected none)", cur_req, k, cyc);
    end else begin
      byte   ek = exp_kind.pop_front();
      int    ec = exp_cyc.pop_front();
      string er = exp_req.pop_front();
      if (ek != k || ec != cyc) begin
        errors++;
        $display("FAIL %s event %c at cycle %0d (expected %c at cycle %0d)", er, k, cyc, ek, ec);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (update_done) take("D");
      if (prev_uip && !uip) take("F");
      if (!prev_uip && uip) take("U");
      if (update_stb) take("S");
    end
    prev_uip <= uip;
  end

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic check_empty(string r);
    checks++;
    if (exp_kind.size() != 0) begin
      errors++;
      $display("FAIL %s %0d expected events missing, next %c at cycle %0d (expected 0 pending)",
               r, exp_kind.size(), exp_kind[0], exp_cyc[0]);
      exp_kind.delete(); exp_cyc.delete(); exp_req.delete();
    end
  endtask

  initial begin
    int s;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if ({update_stb, uip, update_done} != 3'b000) begin
      errors++;
      $display("FAIL R1 outputs after reset %b (expected 000)", {update_stb, uip, update_done});
    end

    cur_req = "R3";
    repeat (20) @(negedge clk);
    c = cyc;
    div_ctl = 3'b010;
    cur_req = "R2";
    push_update(c + HALF, "R3");
    push_update(c + HALF + TPS, "R2");
    push_update(c + HALF + 2 * TPS, "R2");
    s = c + HALF + 2 * TPS;
    wait_until(s + UPD + 2);
    check_empty("R2");

    cur_req = "R4";
    foreach (exp_kind[i]) begin end
    for (int p = 0; p < 5; p++) begin
      case (p)
        0: div_ctl = 3'b000;
        1: div_ctl = 3'b001;
        2: div_ctl = 3'b011;
        3: div_ctl = 3'b100;
        default: div_ctl = 3'b101;
      endcase
      repeat (6) @(negedge clk);
    end
    div_ctl = 3'b010;
    s = s + TPS + 30;
    push_update(s, "R4");
    wait_until(s + UPD + 2);
    check_empty("R4");

    cur_req = "R7";
    set_hold = 1'b1;
    s = s + TPS;
    wait_until(s + UPD + 3);
    set_hold = 1'b0;
    s = s + TPS;
    push_update(s, "R7");
    wait_until(s + UPD + 2);
    check_empty("R7");

    cur_req = "R3";
    div_ctl = 3'b111;
    repeat (10) @(negedge clk);
    c = cyc;
    div_ctl = 3'b010;
    push_update(c + HALF, "R3");
    wait_until(c + HALF + UPD + 2);
    check_empty("R3");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d (expected completion)", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule